// File: doc/BRIEF.md
# Debug Support Unit with Bus Trace

This block is a bus slave that gives a debugger three things through one 2 Mbyte address window. It has control and status registers. It gives access to the processor's register and cache state. It holds a circular trace of bus transfers. Any bus master may issue accesses to the window. The unit can ask the processor to stop. It tracks when the processor reports that it has stopped, and while stopped the processor holds its pipeline so that its state can be read and changed. A snoop input carries the transfers seen on the system bus. The unit records the selected kinds of transfer (instruction fetches, data transfers, or both) into a 64-entry ring.

Each part of the window has its own access condition. The registers are always open. Processor state is open only in debug mode. The trace store is open only while tracing is stopped. An access that breaks its part's condition returns zero, has no effect, and raises an error with the response and in a sticky status bit.

Top module: `dbg_trace_unit`

## Requirements
- R1: The window is decoded by byte address bits [20:19]: 0 registers, 1 processor state, 2 trace, 3 reserved (reads zero, writes ignored, no error). Every request gets a response (rsp_valid_o) exactly one cycle later, and reads return data whether or not the request is a write.
- R2: Register word 0 (offset 0x0) is readable and writable at any time. Its bit 0 enables tracing, bit 1 selects instruction-fetch capture, bit 2 selects data-transfer capture and bit 3 requests a halt. Unused bits, and register word 3, read as zero.
- R3: halt_req_o follows control bit 3. Status word 1 (offset 0x4) bit 0 shows halted_i as sampled one cycle earlier, and this debug-mode flag is what opens the processor state region.
- R4: Processor state word n is at region 1 offset 4*n. It is accessible only while the debug-mode flag is set. A write drives st_we_o with st_addr_o = n in the request cycle, and a read returns st_rdata_i.
- R5: A gated access returns zero data, changes nothing and asserts err_o with its response. It also sets status bit 1, which stays set until any write to the status word clears it.
- R6: While tracing is enabled, each snoop transfer whose kind is selected (snp_instr_i=1 is an instruction fetch, 0 is a data transfer) is stored at the write pointer, and the pointer then advances by one.
- R7: The write pointer reads at register word 2 (offset 0x8), bits [5:0]. It wraps from 63 to 0, and new entries then overwrite the oldest ones.
- R8: A control write takes effect on capture in its own cycle. A snoop transfer in the same cycle as a write that clears the enable is not stored, and a transfer in the same cycle as a write that sets it is stored.
- R9: Trace entry i is at region 2 offset 16*i. Word 0 holds the transfer address, word 1 the data, word 2 bit 0 the kind (1 = instruction), and word 3 reads zero. The region is readable only while the enable bit is 0. Writes to it are ignored without error when tracing is stopped and are gated while it is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write |
| addr_i | input | 21 | Byte address inside the window |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Access was gated |
| halt_req_o | output | 1 | Halt request toward the processor |
| halted_i | input | 1 | Processor reports it is halted |
| st_we_o | output | 1 | Processor state write strobe |
| st_addr_o | output | 6 | Processor state word index |
| st_wdata_o | output | 32 | Processor state write data |
| st_rdata_i | input | 32 | Processor state read data |
| snp_valid_i | input | 1 | Snooped bus transfer valid |
| snp_instr_i | input | 1 | 1 = instruction fetch, 0 = data transfer |
| snp_addr_i | input | 32 | Snooped transfer address |
| snp_data_i | input | 32 | Snooped transfer data |

## Verification
The trace path is exercised with four input patterns, and each one tells apart a different fault:
- Instruction-only capture mixed with data transfers checks that the kind selection filters correctly.
- Both kinds together check that the kind bit is stored.
- A snoop coinciding with the control write that disables tracing separates a same-cycle enable from a registered one.
- More than 64 transfers in a row show whether the pointer wraps and the oldest entries are overwritten.

The processor state and trace regions are each accessed both with their condition met and with it broken. This separates correct gating from gating that only blocks reads or only blocks writes. The later read-back shows whether a gated write leaked through.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  typedef enum logic [1:0] {
    RG_CTRL  = 2'b00,
    RG_STATE = 2'b01,
    RG_TRACE = 2'b10,
    RG_RSVD  = 2'b11
  } region_e;

  typedef struct packed {
    logic halt;
    logic trc_data;
    logic trc_instr;
    logic trc_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dtu_decode.sv
module dtu_decode
  import dtu_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dbg_mode_i,
  input  logic          trace_en_i,
  output region_e       region_o,
  output logic [1:0]    word_o,
  output logic          allow_o,
  output logic          gated_o,
  output logic          ctrl_wr_o,
  output logic          status_wr_o,
  output logic          state_we_o
);
  assign region_o = region_e'(addr_i[AW-1:AW-2]);
  assign word_o   = addr_i[3:2];

  always_comb begin
    unique case (region_o)
      RG_CTRL:  allow_o = 1'b1;
      RG_STATE: allow_o = dbg_mode_i;
      RG_TRACE: allow_o = !trace_en_i;
      default:  allow_o = 1'b1;
    endcase
  end

  assign gated_o     = req_i && !allow_o;
  assign ctrl_wr_o   = req_i && we_i && (region_o == RG_CTRL) && (word_o == 2'd0);
  assign status_wr_o = req_i && we_i && (region_o == RG_CTRL) && (word_o == 2'd1);
  assign state_we_o  = req_i && we_i && (region_o == RG_STATE) && allow_o;
endmodule

// File: rtl/dtu_ctrl_regs.sv
module dtu_ctrl_regs
  import dtu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              status_wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              set_err_i,
  input  logic              halted_i,
  output ctrl_t             ctrl_o,
  output logic              dbg_mode_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      dbg_mode_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      if (ctrl_wr_i) ctrl_o <= ctrl_t'(wdata_i);
      dbg_mode_o <= halted_i;
      if (set_err_i)        err_o <= 1'b1;
      else if (status_wr_i) err_o <= 1'b0;
    end
  end

  // R3
  halt_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_i) |=> dbg_mode_o);
endmodule

// File: rtl/dtu_trace.sv
module dtu_trace #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sel_instr_i,
  input  logic          sel_data_i,
  input  logic          snp_valid_i,
  input  logic          snp_instr_i,
  input  logic [DW-1:0] snp_addr_i,
  input  logic [DW-1:0] snp_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [IW-1:0] wp_o,
  output logic [DW-1:0] rd_addr_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_kind_o
);
  logic [DW-1:0] mem_addr [DEPTH];
  logic [DW-1:0] mem_data [DEPTH];
  logic          mem_kind [DEPTH];
  logic          cap;

  assign cap = en_i && snp_valid_i && (snp_instr_i ? sel_instr_i : sel_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_o <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_addr[i] <= '0;
        mem_data[i] <= '0;
        mem_kind[i] <= 1'b0;
      end
    end else if (cap) begin
      mem_addr[wp_o] <= snp_addr_i;
      mem_data[wp_o] <= snp_data_i;
      mem_kind[wp_o] <= snp_instr_i;
      wp_o           <= wp_o + 1'b1;
    end
  end

  assign rd_addr_o = mem_addr[rd_idx_i];
  assign rd_data_o = mem_data[rd_idx_i];
  assign rd_kind_o = mem_kind[rd_idx_i];

  // R7
  wp_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap && wp_o == IW'(DEPTH-1)) |=> (wp_o == '0));
  // R8
  wp_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(wp_o));
endmodule

// File: rtl/dbg_trace_unit.sv
module dbg_trace_unit
  import dtu_pkg::*;
#(
  parameter int AW       = 21,
  parameter int DW       = 32,
  parameter int ST_AW    = 6,
  parameter int TR_DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             rsp_valid_o,
  output logic [DW-1:0]    rdata_o,
  output logic             err_o,
  output logic             halt_req_o,
  input  logic             halted_i,
  output logic             st_we_o,
  output logic [ST_AW-1:0] st_addr_o,
  output logic [DW-1:0]    st_wdata_o,
  input  logic [DW-1:0]    st_rdata_i,
  input  logic             snp_valid_i,
  input  logic             snp_instr_i,
  input  logic [DW-1:0]    snp_addr_i,
  input  logic [DW-1:0]    snp_data_i
);
  localparam int TIW = $clog2(TR_DEPTH);

  region_e        region;
  logic [1:0]     word;
  logic           allow, gated, ctrl_wr, status_wr;
  ctrl_t          ctrl, ctrl_eff;
  logic           dbg_mode, err_sticky;
  logic [TIW-1:0] wp;
  logic [DW-1:0]  tr_addr, tr_data;
  logic           tr_kind;
  logic [DW-1:0]  rdata_d;

  dtu_decode #(.AW(AW)) u_decode (
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .dbg_mode_i  (dbg_mode),
    .trace_en_i  (ctrl.trc_en),
    .region_o    (region),
    .word_o      (word),
    .allow_o     (allow),
    .gated_o     (gated),
    .ctrl_wr_o   (ctrl_wr),
    .status_wr_o (status_wr),
    .state_we_o  (st_we_o)
  );

  dtu_ctrl_regs u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .status_wr_i (status_wr),
    .wdata_i     (wdata_i[CTRL_W-1:0]),
    .set_err_i   (gated),
    .halted_i    (halted_i),
    .ctrl_o      (ctrl),
    .dbg_mode_o  (dbg_mode),
    .err_o       (err_sticky)
  );

  // control write steers capture in the same cycle
  assign ctrl_eff = ctrl_wr ? ctrl_t'(wdata_i[CTRL_W-1:0]) : ctrl;

  dtu_trace #(.DW(DW), .DEPTH(TR_DEPTH)) u_trace (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_eff.trc_en),
    .sel_instr_i (ctrl_eff.trc_instr),
    .sel_data_i  (ctrl_eff.trc_data),
    .snp_valid_i (snp_valid_i),
    .snp_instr_i (snp_instr_i),
    .snp_addr_i  (snp_addr_i),
    .snp_data_i  (snp_data_i),
    .rd_idx_i    (addr_i[TIW+3:4]),
    .wp_o        (wp),
    .rd_addr_o   (tr_addr),
    .rd_data_o   (tr_data),
    .rd_kind_o   (tr_kind)
  );

  assign halt_req_o = ctrl.halt;
  assign st_addr_o  = addr_i[ST_AW+1:2];
  assign st_wdata_o = wdata_i;

  always_comb begin
    rdata_d = '0;
    if (req_i && allow) begin
      unique case (region)
        RG_CTRL: begin
          unique case (word)
            2'd0:    rdata_d = DW'(ctrl);
            2'd1:    rdata_d = DW'({err_sticky, dbg_mode});
            2'd2:    rdata_d = DW'(wp);
            default: rdata_d = '0;
          endcase
        end
        RG_STATE: rdata_d = st_rdata_i;
        RG_TRACE: begin
          unique case (word)
            2'd0:    rdata_d = tr_addr;
            2'd1:    rdata_d = tr_data;
            2'd2:    rdata_d = DW'(tr_kind);
            default: rdata_d = '0;
          endcase
        end
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rdata_o     <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= req_i;
      rdata_o     <= rdata_d;
      err_o       <= gated;
    end
  end

  // R1
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R5
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  // R4
  state_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we_o |-> dbg_mode);
  // R9
  trace_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && region == RG_TRACE && ctrl.trc_en) |=> err_o);
endmodule

// File: tb/dbg_trace_unit_bench.sv
module dbg_trace_unit_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TD = 64;
  localparam logic [20:0] A_CTRL = 21'h000000, A_STAT = 21'h000004, A_WP = 21'h000008;
  localparam logic [20:0] A_ST = 21'h080000, A_TR = 21'h100000, A_RSV = 21'h180000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req = 0, we = 0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid, err, halt_req, st_we;
  logic [31:0] rdata, st_wdata, st_rdata;
  logic [5:0]  st_addr;
  logic        halted = 0, snp_valid = 0, snp_instr = 0;
  logic [31:0] snp_addr = '0, snp_data = '0;

  dbg_trace_unit u_dbg_trace_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rdata_o(rdata), .err_o(err), .halt_req_o(halt_req),
    .halted_i(halted), .st_we_o(st_we), .st_addr_o(st_addr), .st_wdata_o(st_wdata),
    .st_rdata_i(st_rdata), .snp_valid_i(snp_valid), .snp_instr_i(snp_instr),
    .snp_addr_i(snp_addr), .snp_data_i(snp_data)
  );

  // processor state array on the far side
  logic [31:0] proc_arr [64];
  initial for (int i = 0; i < 64; i++) proc_arr[i] = 32'hA5000000 + i * 32'h00010203;
  assign st_rdata = proc_arr[st_addr];
  always @(posedge clk) if (st_we) proc_arr[st_addr] <= st_wdata;

  int checks = 0, errors = 0;
  string scn = "reset";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", tag, scn, act, exp);
    end
  endtask

  // behavioural reference model
  logic [3:0]  m_ctrl;
  bit          m_err, m_mode;
  int          m_wp;
  logic [31:0] m_ta [TD];
  logic [31:0] m_td [TD];
  bit          m_tk [TD];
  logic [31:0] m_st [64];
  bit          e_valid, e_err;
  logic [31:0] e_rdata;
  string       e_tag;

  initial for (int i = 0; i < 64; i++) m_st[i] = 32'hA5000000 + i * 32'h00010203;

  task automatic model_step();
    int rg, w, idx;
    bit allow;
    logic [3:0] nctrl;
    nctrl = m_ctrl;
    rg = int'(addr[20:19]);
    w = int'(addr[3:2]);
    allow = 1;
    e_valid = req; e_err = 0; e_rdata = '0; e_tag = "R1";
    if (req) begin
      allow = (rg == 0) || (rg == 3) || (rg == 1 && m_mode) || (rg == 2 && !m_ctrl[0]);
      if (!allow) begin
        e_err = 1; e_tag = "R5";
      end else begin
        case (rg)
          0: case (w)
               0: begin e_rdata = {28'd0, m_ctrl}; e_tag = "R2"; if (we) nctrl = wdata[3:0]; end
               1: begin e_rdata = {30'd0, m_err, m_mode}; e_tag = "R3"; end
               2: begin e_rdata = 32'(m_wp); e_tag = "R7"; end
               default: e_tag = "R2";
             endcase
          1: begin
               idx = int'(addr[7:2]); e_rdata = m_st[idx]; e_tag = "R4";
               if (we) m_st[idx] = wdata;
             end
          2: begin
               idx = int'(addr[9:4]); e_tag = "R9";
               case (w)
                 0: e_rdata = m_ta[idx];
                 1: e_rdata = m_td[idx];
                 2: e_rdata = {31'd0, m_tk[idx]};
                 default: e_rdata = '0;
               endcase
             end
          default: e_tag = "R1";
        endcase
      end
    end
    if (snp_valid && nctrl[0] && (snp_instr ? nctrl[1] : nctrl[2])) begin
      m_ta[m_wp] = snp_addr; m_td[m_wp] = snp_data; m_tk[m_wp] = snp_instr;
      m_wp = (m_wp + 1) % TD;
    end
    if (req && !allow) m_err = 1;
    else if (req && we && rg == 0 && w == 1) m_err = 0;
    m_mode = halted;
    m_ctrl = nctrl;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_err = 0; m_mode = 0; m_wp = 0;
      e_valid = 0; e_err = 0; e_rdata = '0; e_tag = "R1";
      for (int i = 0; i < TD; i++) begin m_ta[i] = '0; m_td[i] = '0; m_tk[i] = 0; end
    end else model_step();
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(rsp_valid === 1'b0 && err === 1'b0 && halt_req === 1'b0, "R1 reset",
          {29'd0, rsp_valid, err, halt_req}, 32'd0);
    end else begin
      chk(rsp_valid === e_valid, "R1 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      chk(rdata === e_rdata, e_tag, rdata, e_rdata);
      chk(err === e_err, "R5 err", 32'(err), 32'(e_err));
      chk(halt_req === m_ctrl[3], "R3 halt_req", 32'(halt_req), 32'(m_ctrl[3]));
    end
  end

  task automatic op(input bit w, input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic snoop(input bit k, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    snp_valid = 1; snp_instr = k; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic ctrl_with_snoop(input logic [31:0] c, input bit k, input logic [31:0] a);
    @(negedge clk);
    req = 1; we = 1; addr = A_CTRL; wdata = c;
    snp_valid = 1; snp_instr = k; snp_addr = a; snp_data = ~a;
    @(negedge clk);
    req = 0; we = 0; snp_valid = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    scn = "R2 register defaults";
    op(0, A_CTRL, 0); op(0, A_STAT, 0); op(0, A_WP, 0); op(0, 21'h00000C, 0);
    op(1, A_CTRL, 32'hFFFF_FFF0); op(0, A_CTRL, 0);

    scn = "R6 instruction-only capture";
    op(1, A_CTRL, 32'h3);
    for (int i = 0; i < 5; i++) snoop(i[0], 32'h1000 + i, 32'h2000 + i);
    op(0, A_WP, 0);
    scn = "R9 trace read while running is gated";
    op(0, A_TR, 0); op(1, A_TR + 21'h10, 32'hDEAD);
    op(0, A_STAT, 0);
    scn = "R5 status clear";
    op(1, A_STAT, 0); op(0, A_STAT, 0);

    scn = "R6 both kinds";
    op(1, A_CTRL, 32'h7);
    snoop(0, 32'h3000, 32'h4000); snoop(1, 32'h3004, 32'h4004);
    scn = "R8 disable in same cycle as snoop";
    ctrl_with_snoop(32'h6, 0, 32'h5000);
    snoop(1, 32'h5004, 32'h5008);
    op(0, A_WP, 0);
    scn = "R8 enable in same cycle as snoop";
    ctrl_with_snoop(32'h7, 1, 32'h5100);
    ctrl_with_snoop(32'h0, 1, 32'h5200);
    scn = "R9 trace readout";
    for (int e = 0; e < 6; e++)
      for (int k = 0; k < 4; k++) op(0, A_TR + 21'(e * 16 + k * 4), 0);
    scn = "R9 trace write ignored";
    op(1, A_TR, 32'hBAD0BAD0); op(0, A_TR, 0);

    scn = "R4 state gated before halt";
    op(0, A_ST + 21'h14, 0); op(1, A_ST + 21'h14, 32'h1111_2222); op(0, A_STAT, 0);
    op(1, A_STAT, 0);
    scn = "R3 halt handshake";
    op(1, A_CTRL, 32'h8);
    repeat (2) @(negedge clk);
    halted = 1;
    op(0, A_STAT, 0); op(0, A_STAT, 0);
    scn = "R4 state access in debug mode";
    op(0, A_ST + 21'h14, 0); op(1, A_ST + 21'h14, 32'h1111_2222); op(0, A_ST + 21'h14, 0);
    op(1, A_ST + 21'hFC, 32'h7777_8888); op(0, A_ST + 21'hFC, 0); op(0, A_ST, 0);
    scn = "R3 release";
    op(1, A_CTRL, 32'h0);
    @(negedge clk); halted = 0;
    op(0, A_STAT, 0); op(0, A_ST + 21'h14, 0);

    scn = "R7 pointer wrap";
    op(1, A_CTRL, 32'h7);
    for (int i = 0; i < 70; i++) snoop(i[1], 32'h9000 + i * 4, 32'h100 * i);
    op(1, A_CTRL, 32'h0);
    op(0, A_WP, 0);
    for (int e = 0; e < 8; e++) op(0, A_TR + 21'(e * 16), 0);
    op(0, A_TR + 21'(63 * 16 + 4), 0);

    scn = "R1 reserved region";
    op(0, A_RSV, 0); op(1, A_RSV + 21'h40, 32'h1234); op(0, A_RSV + 21'h40, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule